// File: doc/BRIEF.md
# Low-Power Suspend and Wake Sequencer

This block steps a logic fabric into and out of a low-power suspend state. An external suspend request passes through a synchronizer and, when a configuration bit enables it, through a glitch filter. Three global controls and an awake status then change in a fixed order. The controls are a write-protect that freezes every clocked storage element, an output hold that parks the pads in their suspend behaviour, and an input disable that cuts off inputs and interconnect. The request going low starts the wake sequence, which undoes these steps in reverse order.

Every delay is a count of cycles of the internal clock `clk`. The gaps between entry steps and between wake steps are parameters. After awake rises, write-protect and output hold are released independently. Each release waits either a short count (1 cycle) or a long count (512 cycles), chosen by its own configuration input. If the request returns during the wake sequence, the wake is abandoned. Write-protect comes back at once and the entry sequence resumes from the output-hold step.

In the requirements below, a change of `suspendIn` is driven between clock edges, and edge k means the k-th rising edge after that change. Default parameters are DLY_WP=1, DLY_OUT=2, DLY_SLEEP=2, DLY_INOFF=8, DLY_INON=2, DLY_WAKE=4, FILT_LEN=8, REL_SHORT=1 and REL_LONG=512.

Top module: `suspend_seq`

## Requirements
- R1: During and after reset, with no request, `awake` is 1 and `writeProtect`, `outputHold` and `inputDisable` are 0.
- R2: With the filter off, `writeProtect` rises on edge 3+DLY_WP after `suspendIn` rises, while `awake` is still 1 and `inputDisable` is 0. `outputHold` rises DLY_OUT edges later.
- R3: `awake` falls DLY_SLEEP edges after `outputHold` rises. `inputDisable` rises DLY_INOFF edges after that, and is the last entry step.
- R4: Whenever `awake` is 0, both `writeProtect` and `outputHold` are 1.
- R5: With `filterEn`=1, every entry and exit event is delayed by FILT_LEN extra edges. A pulse on `suspendIn` shorter than FILT_LEN cycles changes no output.
- R6: With the filter off and the entry sequence complete, `inputDisable` falls on edge 3+DLY_INON after `suspendIn` falls. `awake` rises DLY_WAKE edges later.
- R7: `writeProtect` falls REL_SHORT edges after `awake` rises when `wpRelLong`=0, and REL_LONG edges after when it is 1. The value is sampled at the edge on which `awake` rises.
- R8: `outputHold` falls REL_SHORT or REL_LONG edges after `awake` rises, chosen by `holdRelLong` (0 short, 1 long). This choice is independent of `wpRelLong`.
- R9: A request seen during the wake sequence sets `writeProtect` on edge 3 after `suspendIn` rises, and cancels any pending release. Then `awake` falls DLY_OUT+DLY_SLEEP edges later and `inputDisable` rises DLY_INOFF edges after that.
- R10: A request that drops before entry completes does not cut the entry short. The wake sequence begins one edge after `inputDisable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock for all sequencing and counting |
| rstN | input | 1 | Active-low synchronous reset |
| suspendIn | input | 1 | Asynchronous suspend request, high requests suspend |
| filterEn | input | 1 | 1 routes the request through the glitch filter |
| wpRelLong | input | 1 | Write-protect release count: 0 short, 1 long |
| holdRelLong | input | 1 | Output-hold release count: 0 short, 1 long |
| awake | output | 1 | High while the fabric is awake |
| writeProtect | output | 1 | Global write-protect for clocked storage |
| outputHold | output | 1 | Forces outputs to their suspend behaviour |
| inputDisable | output | 1 | Disables inputs and interconnect |

## Verification
The hardest case to reach is the aborted wake. The request has to return while a release count is still running, so that write-protect has already dropped but output hold is still pending. The stimulus gets there by choosing a short write-protect release and a long output-hold release, then raising `suspendIn` twenty cycles after the wake began. A second hard case is a request that falls in the middle of entry. For it, the request is dropped three cycles after it rose, and the wake is expected exactly one edge after the input disable.

// File: rtl/suspend_seq_pkg.sv
package suspend_seq_pkg;

  typedef enum logic [2:0] {
    DLY_SEL_WP,
    DLY_SEL_OUT,
    DLY_SEL_SLEEP,
    DLY_SEL_INOFF,
    DLY_SEL_INON,
    DLY_SEL_WAKE
  } dlySel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENT_WP,
    ST_ENT_OUT,
    ST_ENT_SLEEP,
    ST_ENT_INOFF,
    ST_SUSP,
    ST_EXIT_INON,
    ST_EXIT_WAKE,
    ST_RELEASE
  } seqState_e;

  typedef struct packed {
    logic    loadDly;
    dlySel_e dlySel;
    logic    setWp;
    logic    setHold;
    logic    dropAwake;
    logic    setInDis;
    logic    clrInDis;
    logic    raiseAwake;
    logic    abortRel;
  } seqStrobe_t;

endpackage

// File: rtl/suspend_seq_filter.sv
module suspend_seq_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic filterEn,
  output logic reqLvl
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   filtLvl;
  logic [FW-1:0]          filtCnt;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncLvl = syncChain[SYNC_STAGES-1];

  // The filtered level follows only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      filtCnt <= '0;
    end else if (syncLvl != filtLvl) begin
      if (filtCnt == FW'(FILT_LEN - 1)) begin
        filtLvl <= syncLvl;
        filtCnt <= '0;
      end else begin
        filtCnt <= filtCnt + 1'b1;
      end
    end else begin
      filtCnt <= '0;
    end
  end

  assign reqLvl = filterEn ? filtLvl : syncLvl;

endmodule

// File: rtl/suspend_seq_datapath.sv
module suspend_seq_datapath
  import suspend_seq_pkg::*;
#(
  parameter int DLY_WP    = 1,
  parameter int DLY_OUT   = 2,
  parameter int DLY_SLEEP = 2,
  parameter int DLY_INOFF = 8,
  parameter int DLY_INON  = 2,
  parameter int DLY_WAKE  = 4,
  parameter int REL_SHORT = 1,
  parameter int REL_LONG  = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       wpRelLong,
  input  logic       holdRelLong,
  output logic       dlyDone,
  output logic       relBusy,
  output logic       awake,
  output logic       writeProtect,
  output logic       outputHold,
  output logic       inputDisable
);
  localparam int MAX_A  = (DLY_WP > DLY_OUT) ? DLY_WP : DLY_OUT;
  localparam int MAX_B  = (DLY_SLEEP > DLY_INOFF) ? DLY_SLEEP : DLY_INOFF;
  localparam int MAX_C  = (DLY_INON > DLY_WAKE) ? DLY_INON : DLY_WAKE;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int DW     = $clog2(MAX_D + 1);
  localparam int MAX_R  = (REL_LONG > REL_SHORT) ? REL_LONG : REL_SHORT;
  localparam int RW     = $clog2(MAX_R + 1);
  localparam int NCH    = 2;

  logic [DW-1:0] dlyCnt;
  logic [DW-1:0] dlyLoad;

  always_comb begin
    case (strobe.dlySel)
      DLY_SEL_WP:    dlyLoad = DW'(DLY_WP - 1);
      DLY_SEL_OUT:   dlyLoad = DW'(DLY_OUT - 1);
      DLY_SEL_SLEEP: dlyLoad = DW'(DLY_SLEEP - 1);
      DLY_SEL_INOFF: dlyLoad = DW'(DLY_INOFF - 1);
      DLY_SEL_INON:  dlyLoad = DW'(DLY_INON - 1);
      DLY_SEL_WAKE:  dlyLoad = DW'(DLY_WAKE - 1);
      default:       dlyLoad = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dlyCnt <= '0;
    else if (strobe.loadDly) dlyCnt <= dlyLoad;
    else if (dlyCnt != '0)   dlyCnt <= dlyCnt - 1'b1;
  end

  assign dlyDone = (dlyCnt == '0);

  // Channel 0 times the write-protect release, channel 1 the output-hold release.
  logic [NCH-1:0] relLong;
  logic [NCH-1:0] relAct;
  logic [NCH-1:0] relDone;

  assign relLong = {holdRelLong, wpRelLong};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rel
    logic [RW-1:0] relCnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        relAct[ch] <= 1'b0;
        relCnt     <= '0;
      end else if (strobe.abortRel) begin
        relAct[ch] <= 1'b0;
      end else if (strobe.raiseAwake) begin
        relAct[ch] <= 1'b1;
        relCnt     <= relLong[ch] ? RW'(REL_LONG - 1) : RW'(REL_SHORT - 1);
      end else if (relAct[ch]) begin
        if (relCnt == '0) relAct[ch] <= 1'b0;
        else              relCnt     <= relCnt - 1'b1;
      end
    end
    assign relDone[ch] = relAct[ch] && (relCnt == '0) && !strobe.abortRel;
  end

  assign relBusy = |relAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeProtect <= 1'b0;
      outputHold   <= 1'b0;
      awake        <= 1'b1;
      inputDisable <= 1'b0;
    end else begin
      if (strobe.setWp)        writeProtect <= 1'b1;
      else if (relDone[0])     writeProtect <= 1'b0;
      if (strobe.setHold)      outputHold   <= 1'b1;
      else if (relDone[1])     outputHold   <= 1'b0;
      if (strobe.dropAwake)    awake        <= 1'b0;
      else if (strobe.raiseAwake) awake     <= 1'b1;
      if (strobe.setInDis)     inputDisable <= 1'b1;
      else if (strobe.clrInDis) inputDisable <= 1'b0;
    end
  end

endmodule

// File: rtl/suspend_seq_ctrl.sv
module suspend_seq_ctrl
  import suspend_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqLvl,
  input  logic       dlyDone,
  input  logic       relBusy,
  output seqStrobe_t strobe
);
  seqState_e state;
  seqState_e stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqLvl) begin
          strobe.loadDly = 1'b1;
          strobe.dlySel  = DLY_SEL_WP;
          stateNext      = ST_ENT_WP;
        end
      end
      ST_ENT_WP: begin
        if (dlyDone) begin
          strobe.setWp   = 1'b1;
          strobe.loadDly = 1'b1;
          strobe.dlySel  = DLY_SEL_OUT;
          stateNext      = ST_ENT_OUT;
        end
      end
      ST_ENT_OUT: begin
        if (dlyDone) begin
          strobe.setHold = 1'b1;
          strobe.loadDly = 1'b1;
          strobe.dlySel  = DLY_SEL_SLEEP;
          stateNext      = ST_ENT_SLEEP;
        end
      end
      ST_ENT_SLEEP: begin
        if (dlyDone) begin
          strobe.dropAwake = 1'b1;
          strobe.loadDly   = 1'b1;
          strobe.dlySel    = DLY_SEL_INOFF;
          stateNext        = ST_ENT_INOFF;
        end
      end
      ST_ENT_INOFF: begin
        if (dlyDone) begin
          strobe.setInDis = 1'b1;
          stateNext       = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (!reqLvl) begin
          strobe.loadDly = 1'b1;
          strobe.dlySel  = DLY_SEL_INON;
          stateNext      = ST_EXIT_INON;
        end
      end
      ST_EXIT_INON, ST_EXIT_WAKE, ST_RELEASE: begin
        if (reqLvl) begin
          // Abandon the wake: protect storage now, resume entry at the hold step.
          strobe.setWp    = 1'b1;
          strobe.abortRel = 1'b1;
          strobe.loadDly  = 1'b1;
          strobe.dlySel   = DLY_SEL_OUT;
          stateNext       = ST_ENT_OUT;
        end else if (state == ST_EXIT_INON) begin
          if (dlyDone) begin
            strobe.clrInDis = 1'b1;
            strobe.loadDly  = 1'b1;
            strobe.dlySel   = DLY_SEL_WAKE;
            stateNext       = ST_EXIT_WAKE;
          end
        end else if (state == ST_EXIT_WAKE) begin
          if (dlyDone) begin
            strobe.raiseAwake = 1'b1;
            stateNext         = ST_RELEASE;
          end
        end else if (!relBusy) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/suspend_seq.sv
module suspend_seq
  import suspend_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int DLY_WP      = 1,
  parameter int DLY_OUT     = 2,
  parameter int DLY_SLEEP   = 2,
  parameter int DLY_INOFF   = 8,
  parameter int DLY_INON    = 2,
  parameter int DLY_WAKE    = 4,
  parameter int REL_SHORT   = 1,
  parameter int REL_LONG    = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic suspendIn,
  input  logic filterEn,
  input  logic wpRelLong,
  input  logic holdRelLong,
  output logic awake,
  output logic writeProtect,
  output logic outputHold,
  output logic inputDisable
);
  logic       reqLvl;
  logic       dlyDone;
  logic       relBusy;
  seqStrobe_t strobe;

  suspend_seq_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) uFilter (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (suspendIn),
    .filterEn(filterEn),
    .reqLvl  (reqLvl)
  );

  suspend_seq_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .reqLvl (reqLvl),
    .dlyDone(dlyDone),
    .relBusy(relBusy),
    .strobe (strobe)
  );

  suspend_seq_datapath #(
    .DLY_WP   (DLY_WP),
    .DLY_OUT  (DLY_OUT),
    .DLY_SLEEP(DLY_SLEEP),
    .DLY_INOFF(DLY_INOFF),
    .DLY_INON (DLY_INON),
    .DLY_WAKE (DLY_WAKE),
    .REL_SHORT(REL_SHORT),
    .REL_LONG (REL_LONG)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wpRelLong   (wpRelLong),
    .holdRelLong (holdRelLong),
    .dlyDone     (dlyDone),
    .relBusy     (relBusy),
    .awake       (awake),
    .writeProtect(writeProtect),
    .outputHold  (outputHold),
    .inputDisable(inputDisable)
  );

endmodule

// File: rtl/suspend_seq_chk.sv
module suspend_seq_chk (
  input logic clk,
  input logic rstN,
  input logic suspendIn,
  input logic filterEn,
  input logic wpRelLong,
  input logic holdRelLong,
  input logic awake,
  input logic writeProtect,
  input logic outputHold,
  input logic inputDisable
);
  AST_WP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeProtect) |-> awake && !inputDisable); // R2
  AST_HOLD_AFTER_WP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outputHold) |-> writeProtect); // R2
  AST_SLEEP_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(awake) |-> outputHold && writeProtect && !inputDisable); // R3
  AST_INDIS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inputDisable) |-> !awake && outputHold && writeProtect); // R3
  AST_ASLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> writeProtect && outputHold); // R4
  AST_WAKE_AFTER_INEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awake) |-> !inputDisable); // R6
  AST_WP_REL_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeProtect) |-> awake && !inputDisable); // R7
  AST_HOLD_REL_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outputHold) |-> awake && !inputDisable); // R8
endmodule

bind suspend_seq suspend_seq_chk uChk (.*);

// File: tb/tb_suspend_seq.sv
module tb_suspend_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 8, DWP = 1, DOUT = 2, DSLP = 2, DINOFF = 8, DINON = 2, DWAKE = 4;
  localparam int RSHORT = 1, RLONG = 512;

  localparam int EV_WP_ON = 0, EV_WP_OFF = 1, EV_HOLD_ON = 2, EV_HOLD_OFF = 3;
  localparam int EV_SLEEP = 4, EV_WAKE = 5, EV_IN_OFF = 6, EV_IN_ON = 7;

  logic clk = 1'b0;
  logic rstN;
  logic suspendIn, filterEn, wpRelLong, holdRelLong;
  logic awake, writeProtect, outputHold, inputDisable;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  logic pWp, pHold, pAwake, pInDis;

  typedef struct {
    int    code;
    int    at;
    string tag;
  } exp_t;
  exp_t expQ[$];

  suspend_seq dut (
    .clk(clk), .rstN(rstN), .suspendIn(suspendIn), .filterEn(filterEn),
    .wpRelLong(wpRelLong), .holdRelLong(holdRelLong), .awake(awake),
    .writeProtect(writeProtect), .outputHold(outputHold), .inputDisable(inputDisable)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic pushExp(input int code, input int at, input string tag);
    exp_t e;
    e.code = code;
    e.at   = at;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  task automatic seen(input int code);
    exp_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R4", "unexpected output event", code, -1);
    end else begin
      e = expQ.pop_front();
      check(e.code == code, e.tag, "event code", code, e.code);
      check(e.at == cyc, e.tag, "event cycle", cyc, e.at);
    end
  endtask

  // Monitor: reports changes in a fixed order per cycle (wp, hold, awake, inputs).
  always @(negedge clk) begin
    if (monOn) begin
      if (writeProtect !== pWp)  seen(writeProtect ? EV_WP_ON : EV_WP_OFF);
      if (outputHold !== pHold)  seen(outputHold ? EV_HOLD_ON : EV_HOLD_OFF);
      if (awake !== pAwake)      seen(awake ? EV_WAKE : EV_SLEEP);
      if (inputDisable !== pInDis) seen(inputDisable ? EV_IN_OFF : EV_IN_ON);
      pWp = writeProtect;
      pHold = outputHold;
      pAwake = awake;
      pInDis = inputDisable;
    end
  end

  task automatic waitUntil(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic checkEmpty(input string tag);
    check(expQ.size() == 0, tag, "missing events", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic checkIdle(input string tag);
    check(awake == 1'b1, tag, "awake", awake, 1);
    check(writeProtect == 1'b0, tag, "writeProtect", writeProtect, 0);
    check(outputHold == 1'b0, tag, "outputHold", outputHold, 0);
    check(inputDisable == 1'b0, tag, "inputDisable", inputDisable, 0);
  endtask

  // Pushes the four entry events; returns the cycle of the input disable.
  task automatic pushEntry(input int base, input string tag, output int inOff);
    int tWp, tHold, tSleep;
    tWp   = base + DWP;
    tHold = tWp + DOUT;
    tSleep = tHold + DSLP;
    inOff = tSleep + DINOFF;
    pushExp(EV_WP_ON, tWp, tag);
    pushExp(EV_HOLD_ON, tHold, tag);
    pushExp(EV_SLEEP, tSleep, "R3");
    pushExp(EV_IN_OFF, inOff, "R3");
  endtask

  // Pushes the wake events from the edge the controller sees the drop; returns the last cycle.
  task automatic pushExit(input int t1, input bit wl, input bit hl, output int last);
    int tIn, tWake, tWp, tHold;
    tIn   = t1 + DINON;
    tWake = tIn + DWAKE;
    tWp   = tWake + (wl ? RLONG : RSHORT);
    tHold = tWake + (hl ? RLONG : RSHORT);
    pushExp(EV_IN_ON, tIn, "R6");
    pushExp(EV_WAKE, tWake, "R6");
    if (tWp <= tHold) begin
      pushExp(EV_WP_OFF, tWp, "R7");
      pushExp(EV_HOLD_OFF, tHold, "R8");
    end else begin
      pushExp(EV_HOLD_OFF, tHold, "R8");
      pushExp(EV_WP_OFF, tWp, "R7");
    end
    last = (tWp > tHold) ? tWp : tHold;
  endtask

  task automatic enterSeq(input bit filt, input string tag);
    int c, inOff;
    @(negedge clk);
    c = cyc;
    suspendIn = 1'b1;
    pushEntry(c + 3 + (filt ? FL : 0), tag, inOff);
    waitUntil(inOff + 3);
    checkEmpty(tag);
  endtask

  task automatic exitSeq(input bit filt, input bit wl, input bit hl, input string tag);
    int d, last;
    @(negedge clk);
    wpRelLong = wl;
    holdRelLong = hl;
    d = cyc;
    suspendIn = 1'b0;
    pushExit(d + 3 + (filt ? FL : 0), wl, hl, last);
    waitUntil(last + 4);
    checkEmpty(tag);
    checkIdle(tag);
  endtask

  task automatic finishTest();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 150000);
    finishTest();
  end

  initial begin
    int a, d, c, inOff, last;
    rstN = 1'b0;
    suspendIn = 1'b0;
    filterEn = 1'b0;
    wpRelLong = 1'b0;
    holdRelLong = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    pWp = writeProtect;
    pHold = outputHold;
    pAwake = awake;
    pInDis = inputDisable;
    monOn = 1'b1;

    // Plain entry and exit, both releases short.
    enterSeq(1'b0, "R2");
    exitSeq(1'b0, 1'b0, 1'b0, "R7");

    // Long write-protect release, short hold release.
    enterSeq(1'b0, "R2");
    exitSeq(1'b0, 1'b1, 1'b0, "R7");

    // Short glitch rejected by the filter.
    @(negedge clk);
    filterEn = 1'b1;
    repeat (4) @(negedge clk);
    suspendIn = 1'b1;
    repeat (FL - 1) @(negedge clk);
    suspendIn = 1'b0;
    repeat (40) @(negedge clk);
    checkEmpty("R5");
    checkIdle("R5");

    // Filtered entry and exit, both releases long.
    enterSeq(1'b1, "R5");
    exitSeq(1'b1, 1'b1, 1'b1, "R5");
    @(negedge clk);
    filterEn = 1'b0;
    repeat (4) @(negedge clk);

    // Aborted wake: write-protect released, hold still counting.
    enterSeq(1'b0, "R2");
    @(negedge clk);
    wpRelLong = 1'b0;
    holdRelLong = 1'b1;
    d = cyc;
    suspendIn = 1'b0;
    pushExp(EV_IN_ON, d + 3 + DINON, "R6");
    pushExp(EV_WAKE, d + 3 + DINON + DWAKE, "R6");
    pushExp(EV_WP_OFF, d + 3 + DINON + DWAKE + RSHORT, "R7");
    waitUntil(d + 20);
    a = cyc;
    suspendIn = 1'b1;
    pushExp(EV_WP_ON, a + 3, "R9");
    pushExp(EV_SLEEP, a + 3 + DOUT + DSLP, "R9");
    pushExp(EV_IN_OFF, a + 3 + DOUT + DSLP + DINOFF, "R9");
    waitUntil(a + 3 + DOUT + DSLP + DINOFF + RLONG);
    checkEmpty("R9");
    check(outputHold == 1'b1, "R9", "hold kept after abort", outputHold, 1);
    exitSeq(1'b0, 1'b0, 1'b0, "R9");

    // Request drops during entry: entry completes, wake follows one edge later.
    @(negedge clk);
    wpRelLong = 1'b0;
    holdRelLong = 1'b0;
    c = cyc;
    suspendIn = 1'b1;
    repeat (3) @(negedge clk);
    suspendIn = 1'b0;
    pushEntry(c + 3, "R10", inOff);
    pushExit(inOff + 1, 1'b0, 1'b0, last);
    waitUntil(last + 4);
    checkEmpty("R10");
    checkIdle("R10");

    finishTest();
  end

endmodule